// File: doc/BRIEF.md
# Programmable Interrupt Source Aggregator

The block gathers thirty-two interrupt sources, coming from four serial channels with eight sources each, into one active-high request line. Each source passes through one capture register and is then compared with its previous sample. The block watches each source for a chosen edge or level, records what it sees in a status register, and raises the request while any recorded source is also enabled.

Software reaches four 32-bit registers through a simple synchronous port: enable, status, trigger mode and polarity. Bit n of every register belongs to source n. FIFO-flag sources can be set to any combination of trigger mode and polarity. The sync-detect sources always trigger on a rising edge, and the serial-controller sources are always level-high. Their mode and polarity bits can still be written and read back, but they change nothing.

Top module: `irq_aggregator`

## Requirements
- R1: The register address selects the register: 0 = enable, 1 = status, 2 = trigger mode (bit 1 = level, 0 = edge), 3 = polarity (bit 1 = alternate: falling edge or active-low level). Bit n of each register belongs to source n. Reads of enable, mode and polarity return the last value written.
- R2: After reset, the enable, mode, polarity and status registers all read 0 and the request output is 0, provided every source is held low.
- R3: A FIFO-flag source in edge mode with polarity 0 sets its status bit when the flag goes from 0 to 1. The bit is visible by the second rising clock edge after the input changes.
- R4: A FIFO-flag source in edge mode with polarity 1 sets its status bit only when the flag goes from 1 to 0.
- R5: A FIFO-flag source in level mode has a status bit equal to the registered flag, inverted when polarity is 1. Writes to the status register do not change such a bit.
- R6: Sources 4c for c = 0..3 are sync-detect sources. They set status only on a 0-to-1 transition, whatever their mode and polarity bits hold.
- R7: Sources 4c+3 for c = 0..3 are serial-controller sources. Their status equals the registered source level, whatever their mode and polarity bits hold. Writes to status do not change it.
- R8: An edge-mode status bit stays set until a status write has a 1 in that bit. A 0 in that bit of a write leaves it unchanged.
- R9: When a detected edge and a clearing write meet a status bit in the same cycle, the bit ends up set.
- R10: A status bit records events even while its enable bit is 0. The request output is the OR of all status bits that are enabled, and it follows a change of enable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| src_i | input | 32 | Interrupt source levels, bit n = source n |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register, combinational |
| irq_o | output | 1 | Aggregated interrupt request, active high |

## Verification
The bench sweeps every source through all four mode and polarity settings. For each one it drives a low–high–low pulse and checks both the status bit and the request against values derived from the source's kind. A design that ignored the hardware-fixed trigger would show the wrong status on the sync-detect or serial-controller sources. A design with swapped polarity would flag the wrong transition. A design with a stale level path would hold a level bit that should have dropped. Directed cases also cover four more faults: a clear and an edge landing in the same cycle, where the wrong priority would lose the event; a write of 0 to status, which must not clear; a status write to a level bit, which must have no effect; and a source recorded while disabled, which must raise the request only once it is enabled.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;

  typedef enum logic [1:0] {
    REG_ENABLE   = 2'd0,
    REG_STATUS   = 2'd1,
    REG_MODE     = 2'd2,
    REG_POLARITY = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SRC_FIFO = 2'd0,
    SRC_SYNC = 2'd1,
    SRC_CTRL = 2'd2
  } src_kind_e;

  // Lower half: per channel sync, tx-almost-empty, rx-almost-full, controller.
  // Upper half: FIFO flags only.
  function automatic src_kind_e kind_of(input int idx, input int nchan);
    if (idx < 4 * nchan) begin
      if (idx % 4 == 0)      return SRC_SYNC;
      else if (idx % 4 == 3) return SRC_CTRL;
      else                   return SRC_FIFO;
    end
    return SRC_FIFO;
  endfunction

endpackage

// File: rtl/irq_rst_sync.sv
`timescale 1ns/1ps
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_src_cell.sv
`timescale 1ns/1ps
module irq_src_cell
  import irq_agg_pkg::*;
#(
  parameter src_kind_e KIND = SRC_FIFO
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic mode_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic status_o
);
  logic src_q, src_d;
  logic status_q, status_d;
  logic eff_level, eff_pol;
  logic det_edge, lvl;

  // Hardware-fixed kinds override the software choice.
  always_comb begin
    eff_level = (KIND == SRC_CTRL) | ((KIND == SRC_FIFO) & mode_i);
    eff_pol   = (KIND == SRC_FIFO) & pol_i;
  end

  always_comb begin
    det_edge = eff_pol ? (~src_q & src_d) : (src_q & ~src_d);
    lvl      = src_q ^ eff_pol;
    if (eff_level)     status_d = lvl;
    else if (det_edge) status_d = 1'b1;
    else if (clr_i)    status_d = 1'b0;
    else               status_d = status_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= 1'b0;
      src_d    <= 1'b0;
      status_q <= 1'b0;
    end else begin
      src_q    <= src_i;
      src_d    <= src_q;
      status_q <= status_d;
    end
  end

  assign status_o = status_q;

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!eff_level && det_edge) |=> status_q); // R9

  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!eff_level && clr_i && !det_edge && $stable(mode_i)) |=> !status_q); // R8

  AST_HOLD_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!eff_level && status_q && !clr_i && $stable(mode_i)) |=> status_q); // R8

  generate
    if (KIND == SRC_SYNC) begin : g_sync_chk
      AST_SYNC_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q) |-> $past(src_q)); // R6
    end
  endgenerate
endmodule

// File: rtl/irq_agg_regs.sv
`timescale 1ns/1ps
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] status_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] mode_o,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] clr_o,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] en_q, en_d;
  logic [W-1:0] mode_q, mode_d;
  logic [W-1:0] pol_q, pol_d;
  reg_sel_e     sel;

  assign sel = reg_sel_e'(addr_i);

  always_comb begin
    en_d   = en_q;
    mode_d = mode_q;
    pol_d  = pol_q;
    clr_o  = '0;
    if (wr_i) begin
      case (sel)
        REG_ENABLE:   en_d   = wdata_i;
        REG_STATUS:   clr_o  = wdata_i;
        REG_MODE:     mode_d = wdata_i;
        REG_POLARITY: pol_d  = wdata_i;
        default:      en_d   = en_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '0;
      pol_q  <= '0;
    end else begin
      en_q   <= en_d;
      mode_q <= mode_d;
      pol_q  <= pol_d;
    end
  end

  always_comb begin
    case (sel)
      REG_ENABLE:   rdata_o = en_q;
      REG_STATUS:   rdata_o = status_i;
      REG_MODE:     rdata_o = mode_q;
      REG_POLARITY: rdata_o = pol_q;
      default:      rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign pol_o  = pol_q;

  AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == 2'd0) |=> en_q == $past(wdata_i)); // R1

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ($stable(en_q) && $stable(mode_q) && $stable(pol_q))); // R1
endmodule

// File: rtl/irq_aggregator.sv
`timescale 1ns/1ps
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_CHAN = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [8*NUM_CHAN-1:0]   src_i,
  input  logic                    reg_wr_i,
  input  logic [1:0]              reg_addr_i,
  input  logic [8*NUM_CHAN-1:0]   reg_wdata_i,
  output logic [8*NUM_CHAN-1:0]   reg_rdata_o,
  output logic                    irq_o
);
  localparam int NUM_SRC = 8 * NUM_CHAN;

  logic               rst_int_n;
  logic [NUM_SRC-1:0] en_v, mode_v, pol_v, clr_v, status_v;

  irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  irq_agg_regs #(.W(NUM_SRC)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .status_i (status_v),
    .en_o     (en_v),
    .mode_o   (mode_v),
    .pol_o    (pol_v),
    .clr_o    (clr_v),
    .rdata_o  (reg_rdata_o)
  );

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      irq_src_cell #(.KIND(kind_of(g, NUM_CHAN))) u_cell (
        .clk      (clk),
        .rst_n    (rst_int_n),
        .src_i    (src_i[g]),
        .mode_i   (mode_v[g]),
        .pol_i    (pol_v[g]),
        .clr_i    (clr_v[g]),
        .status_o (status_v[g])
      );
    end
  endgenerate

  assign irq_o = |(status_v & en_v);

  // Cycles since internal reset release, saturating; used by the checks.
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)        warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o |-> (en_v != '0)); // R10

  generate
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_ctrl_chk
      AST_CTRL_LEVEL: assert property (@(posedge clk) disable iff (!rst_int_n)
        (warm_q >= 2'd2) |-> (status_v[4*c+3] == $past(src_i[4*c+3], 2))); // R7
    end
  endgenerate
endmodule

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC       = 32;
  localparam int WD_LIMIT   = 100000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] src;
  logic            wr;
  logic [1:0]      addr;
  logic [NSRC-1:0] wdata;
  logic [NSRC-1:0] rdata;
  logic            irq;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src),
    .reg_wr_i    (wr),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == WD_LIMIT) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    addr  = a;
    wdata = d;
    wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr    = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // Kind from the index map: 0 fifo, 1 sync, 2 controller.
  function automatic int kind(input int i);
    if (i < 16 && i % 4 == 0) return 1;
    if (i < 16 && i % 4 == 3) return 2;
    return 0;
  endfunction

  initial begin
    logic [31:0] rv;
    rst_n = 1'b0;
    src   = '0;
    wr    = 1'b0;
    addr  = '0;
    wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(5);

    // R2: reset state
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), rv);
      check("R2 reset register", rv, 32'h0);
    end
    check("R2 reset irq", {31'b0, irq}, 32'h0);

    // R1: readback of configuration registers
    reg_write(2'd0, 32'hA5C3_0F81);
    reg_write(2'd2, 32'h1234_5678);
    reg_write(2'd3, 32'hFEDC_BA98);
    reg_read(2'd0, rv); check("R1 enable readback", rv, 32'hA5C3_0F81);
    reg_read(2'd2, rv); check("R1 mode readback", rv, 32'h1234_5678);
    reg_read(2'd3, rv); check("R1 polarity readback", rv, 32'hFEDC_BA98);

    // Sweep: every source, every mode/polarity combination, low-high-low pulse.
    for (int i = 0; i < NSRC; i++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        int    k;
        bit    m, p, el, ep;
        string tag;
        logic  exp_a, exp_b, exp_c;
        k  = kind(i);
        m  = cfg[1];
        p  = cfg[0];
        el = (k == 2) || (k == 0 && m);
        ep = (k == 0) && p;
        if (k == 1)      tag = "R6";
        else if (k == 2) tag = "R7";
        else if (m)      tag = "R5";
        else if (p)      tag = "R4";
        else             tag = "R3";
        exp_a = el ? ep : 1'b0;
        exp_b = el ? !ep : !ep;
        exp_c = el ? ep : 1'b1;
        src = '0;
        reg_write(2'd2, m ? 32'hFFFF_FFFF : 32'h0);
        reg_write(2'd3, p ? 32'hFFFF_FFFF : 32'h0);
        reg_write(2'd0, 32'h1 << i);
        tick(3);
        reg_write(2'd1, 32'hFFFF_FFFF);
        tick(1);
        reg_read(2'd1, rv);
        check({tag, " idle status"}, {31'b0, rv[i]}, {31'b0, exp_a});
        check({tag, " idle irq"}, {31'b0, irq}, {31'b0, exp_a});
        src[i] = 1'b1;
        tick(3);
        reg_read(2'd1, rv);
        check({tag, " high status"}, {31'b0, rv[i]}, {31'b0, exp_b});
        check({tag, " high irq"}, {31'b0, irq}, {31'b0, exp_b});
        src[i] = 1'b0;
        tick(3);
        reg_read(2'd1, rv);
        check({tag, " low status"}, {31'b0, rv[i]}, {31'b0, exp_c});
        check({tag, " low irq"}, {31'b0, irq}, {31'b0, exp_c});
      end
    end

    // Back to edge/rising for all, clear everything.
    src = '0;
    reg_write(2'd2, 32'h0);
    reg_write(2'd3, 32'h0);
    reg_write(2'd0, 32'h1 << 16);
    tick(3);
    reg_write(2'd1, 32'hFFFF_FFFF);

    // R9: edge and clear in the same cycle, edge wins
    src[16] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_write(2'd1, 32'hFFFF_FFFF);
    reg_read(2'd1, rv);
    check("R9 edge beats clear", {31'b0, rv[16]}, 32'h1);

    // R8: writing 0 leaves the bit, writing 1 clears it
    reg_write(2'd1, 32'h0);
    reg_read(2'd1, rv);
    check("R8 zero write no effect", {31'b0, rv[16]}, 32'h1);
    check("R8 irq still set", {31'b0, irq}, 32'h1);
    reg_write(2'd1, 32'h1 << 16);
    reg_read(2'd1, rv);
    check("R8 one write clears", {31'b0, rv[16]}, 32'h0);
    check("R8 irq drops", {31'b0, irq}, 32'h0);

    // R10: captured while disabled, request follows enable
    reg_write(2'd0, 32'h0);
    src[17] = 1'b1;
    tick(3);
    reg_read(2'd1, rv);
    check("R10 status while disabled", {31'b0, rv[17]}, 32'h1);
    check("R10 no irq while disabled", {31'b0, irq}, 32'h0);
    reg_write(2'd0, 32'h1 << 17);
    check("R10 irq after enable", {31'b0, irq}, 32'h1);

    // R5: status write leaves a level bit alone
    reg_write(2'd2, 32'h1 << 18);
    src[18] = 1'b1;
    tick(3);
    reg_write(2'd1, 32'h1 << 18);
    reg_read(2'd1, rv);
    check("R5 level bit ignores clear", {31'b0, rv[18]}, 32'h1);

    // R7: controller source ignores status write
    src[7] = 1'b1;
    tick(3);
    reg_write(2'd1, 32'h1 << 7);
    reg_read(2'd1, rv);
    check("R7 controller bit ignores clear", {31'b0, rv[7]}, 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule